// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block is the bit-level engine for a small register port that uses a chip enable, a bit clock and one shared data line. A host hands it one register access at a time through a request/ready handshake. The block builds the byte sequence for that access and shifts it out most significant bit first. For a read it also shifts the reply byte back in and returns its low nibble. The shared data line appears as three separate signals: a driven value, an output enable and a sampled input. A tri-state pad or an open-drain wrapper outside the block combines them.

The bit clock comes from a parameterised divider. Each half-period lasts `HALF_CYC` system clock cycles; 70 cycles at 100 MHz gives about 700 ns. The block does not drive the chip enable. It only refuses to start an access while the enable input is low. Decoding the register contents is outside its scope.

Top module: `sreg3w_master`

## Requirements
- R1: After reset `scl` is 1, `sda_oe` is 0, `ready` is 1, `done` is 0 and `rd_data` is 0.
- R2: A request is taken on a clock edge where `req_valid`, `ready` and `ce` are all 1. From the next cycle `ready` stays 0 until the access ends, and each request produces exactly one access.
- R3: Bytes go out most significant bit first. For every bit `scl` is low for exactly `HALF_CYC` cycles, and before every falling edge it has been high for at least `HALF_CYC` cycles. `sda_out` and `sda_oe` do not change while `scl` is low.
- R4: A write sends two bytes. The first is `0x20 | addr` (bit 5 marks an address phase). The second is `0x10 | data` (bit 4 marks a data phase, with the nibble in bits 3:0).
- R5: A read sends one byte, `0x60 | addr` (bit 6 is the read flag and bit 5 the address flag). It then clocks eight more bits in while `sda_oe` stays 0.
- R6: For each byte sent, `sda_oe` rises one cycle after the first bit value is on `sda_out`, while `scl` is high. It stays 1 across all eight bits and returns to 0 when `scl` rises at the end of the eighth bit.
- R7: A received bit is sampled from `sda_in` in the last cycle of the high phase, before `scl` falls. Bits arrive most significant first, and `rd_data` receives bits 3:0 of the received byte. The upper nibble is discarded.
- R8: `done` is a single-cycle pulse that ends every access, with `ready` returning to 1 in the same cycle. A write leaves `rd_data` unchanged.
- R9: `scl` is 1 in every cycle in which `ready` is 1.
- R10: A request presented while `ce` is 0 is ignored: `ready` stays 1, `scl` stays 1 and `sda_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable level; an access starts only while it is 1 |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Register address |
| req_data | input | 4 | Write nibble |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 4 | Low nibble of the last reply |
| scl | output | 1 | Bit clock, high when idle |
| sda_out | output | 1 | Value driven on the data line |
| sda_oe | output | 1 | Data line output enable |
| sda_in | input | 1 | Value sampled from the data line |

## Verification
The properties assume that `rst` is held for a few cycles at start-up. They also assume that `ce` is only lowered while the block is idle, so no access is ever cut short. The bench meets both assumptions: it raises `ce` during reset and lowers it only for the ignored-request test, when no access is running. The bench also models the far end of the data line. It changes `sda_in` only just after `scl` rises, which leaves the value settled for at least `HALF_CYC - 1` cycles before the sampling edge. `HALF_CYC` is 4, so each read bit is sampled well inside its high phase.

// File: rtl/sreg3w_pkg.sv
package sreg3w_pkg;
  localparam int ADDR_W = 4;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FLAG_RD = 8'h40;
  localparam logic [BYTE_W-1:0] FLAG_AD = 8'h20;
  localparam logic [BYTE_W-1:0] FLAG_DT = 8'h10;

  typedef enum logic [1:0] {BS_IDLE, BS_HIGH, BS_LOW} bit_state_t;
  typedef enum logic [1:0] {TS_IDLE, TS_CMD, TS_PAY} xfer_state_t;

  function automatic logic [BYTE_W-1:0] fmt_cmd(input logic [ADDR_W-1:0] a, input logic rd);
    fmt_cmd = BYTE_W'(a) | FLAG_AD | (rd ? FLAG_RD : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] fmt_dat(input logic [NIB_W-1:0] d);
    fmt_dat = BYTE_W'(d) | FLAG_DT;
  endfunction
endpackage

// File: rtl/sreg3w_halfdiv.sv
module sreg3w_halfdiv #(
  parameter int HALF_CYC = 70
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic last
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST_V = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (last)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sreg3w_cmdfmt.sv
module sreg3w_cmdfmt
  import sreg3w_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  data,
  input  logic              is_read,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] dat_byte
);
  always_comb begin
    cmd_byte = fmt_cmd(addr, is_read);
    dat_byte = fmt_dat(data);
  end
endmodule

// File: rtl/sreg3w_bitseq.sv
module sreg3w_bitseq
  import sreg3w_pkg::*;
#(
  parameter int HALF_CYC = 70,
  parameter int BITS     = 8,
  parameter int KEEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tx_mode,
  input  logic [BITS-1:0]   tx_byte,
  input  logic              sda_in,
  output logic              fin,
  output logic              scl,
  output logic              sda_out,
  output logic              sda_oe,
  output logic [KEEP_W-1:0] rx_keep
);
  localparam int BW = $clog2(BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  bit_state_t     st;
  logic           ph_last;
  logic           div_clr;
  logic           tx;
  logic [BW-1:0]  bit_idx;
  logic [BITS-1:0] sh;

  assign div_clr = (st == BS_IDLE);

  sreg3w_halfdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (div_clr),
    .last (ph_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BS_IDLE;
      scl     <= 1'b1;
      sda_out <= 1'b0;
      sda_oe  <= 1'b0;
      fin     <= 1'b0;
      tx      <= 1'b0;
      bit_idx <= '0;
      sh      <= '0;
      rx_keep <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        BS_IDLE: begin
          if (start) begin
            st      <= BS_HIGH;
            tx      <= tx_mode;
            sh      <= tx_byte;
            bit_idx <= '0;
            sda_out <= tx_mode & tx_byte[BITS-1];
          end
        end
        BS_HIGH: begin
          // enable the line one cycle after the first value is placed
          if (tx && !sda_oe) sda_oe <= 1'b1;
          if (ph_last) begin
            scl <= 1'b0;
            st  <= BS_LOW;
            if (!tx) sh <= {sh[BITS-2:0], sda_in};
          end
        end
        BS_LOW: begin
          if (ph_last) begin
            scl <= 1'b1;
            if (bit_idx == LAST_BIT) begin
              st      <= BS_IDLE;
              sda_oe  <= 1'b0;
              sda_out <= 1'b0;
              fin     <= 1'b1;
              if (!tx) rx_keep <= sh[KEEP_W-1:0];
            end else begin
              st      <= BS_HIGH;
              bit_idx <= bit_idx + 1'b1;
              if (tx) begin
                sh      <= {sh[BITS-2:0], sh[BITS-1]};
                sda_out <= sh[BITS-2];
              end
            end
          end
        end
        default: st <= BS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sreg3w_master.sv
module sreg3w_master
  import sreg3w_pkg::*;
#(
  parameter int HALF_CYC = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NIB_W-1:0]  req_data,
  output logic              ready,
  output logic              done,
  output logic [NIB_W-1:0]  rd_data,
  output logic              scl,
  output logic              sda_out,
  output logic              sda_oe,
  input  logic              sda_in
);
  xfer_state_t       ts;
  logic              lat_wr;
  logic [ADDR_W-1:0] lat_addr;
  logic [NIB_W-1:0]  lat_data;
  logic              seq_start;
  logic              seq_tx;
  logic              seq_fin;
  logic [BYTE_W-1:0] cmd_byte;
  logic [BYTE_W-1:0] dat_byte;
  logic [BYTE_W-1:0] seq_byte;
  logic [NIB_W-1:0]  seq_rx;

  sreg3w_cmdfmt u_fmt (
    .addr     (lat_addr),
    .data     (lat_data),
    .is_read  (!lat_wr),
    .cmd_byte (cmd_byte),
    .dat_byte (dat_byte)
  );

  assign seq_byte = (ts == TS_CMD) ? cmd_byte : dat_byte;

  sreg3w_bitseq #(
    .HALF_CYC (HALF_CYC),
    .BITS     (BYTE_W),
    .KEEP_W   (NIB_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (seq_start),
    .tx_mode (seq_tx),
    .tx_byte (seq_byte),
    .sda_in  (sda_in),
    .fin     (seq_fin),
    .scl     (scl),
    .sda_out (sda_out),
    .sda_oe  (sda_oe),
    .rx_keep (seq_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts        <= TS_IDLE;
      ready     <= 1'b1;
      done      <= 1'b0;
      rd_data   <= '0;
      seq_start <= 1'b0;
      seq_tx    <= 1'b1;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
    end else begin
      done      <= 1'b0;
      seq_start <= 1'b0;
      case (ts)
        TS_IDLE: begin
          if (req_valid && ce) begin
            lat_wr    <= req_write;
            lat_addr  <= req_addr;
            lat_data  <= req_data;
            ready     <= 1'b0;
            seq_start <= 1'b1;
            seq_tx    <= 1'b1;
            ts        <= TS_CMD;
          end
        end
        TS_CMD: begin
          if (seq_fin) begin
            seq_start <= 1'b1;
            seq_tx    <= lat_wr;
            ts        <= TS_PAY;
          end
        end
        TS_PAY: begin
          if (seq_fin) begin
            done  <= 1'b1;
            ready <= 1'b1;
            if (!lat_wr) rd_data <= seq_rx;
            ts    <= TS_IDLE;
          end
        end
        default: ts <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sreg3w_master_chk.sv
module sreg3w_master_chk #(
  parameter int HALF_CYC = 70
) (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic req_valid,
  input logic ready,
  input logic done,
  input logic scl,
  input logic sda_out,
  input logic sda_oe
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)      low_run <= '0;
    else if (scl) low_run <= '0;
    else          low_run <= low_run + 1'b1;
  end

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && ce) |=> !ready);

  a_r10_ce_low_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && !ce) |=> ready);

  a_r3_low_phase_length: assert property (@(posedge clk) disable iff (rst)
    $rose(scl) |-> (low_run == 16'(HALF_CYC)));

  a_r3_data_stable_low: assert property (@(posedge clk) disable iff (rst)
    (!scl && $past(!scl)) |-> ($stable(sda_out) && $stable(sda_oe)));

  a_r6_enable_after_place: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> (scl && $stable(sda_out)));

  a_r6_enable_only_busy: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> !ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  a_r9_idle_scl_high: assert property (@(posedge clk) disable iff (rst)
    ready |-> scl);
endmodule

bind sreg3w_master sreg3w_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .scl       (scl),
  .sda_out   (sda_out),
  .sda_oe    (sda_oe)
);

// File: tb/sim_sreg3w_master.sv
module sim_sreg3w_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [3:0] req_data = '0;
  logic       sda_in = 1'b0;
  logic       ready, done, scl, sda_out, sda_oe;
  logic [3:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg3w_master #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .ready(ready), .done(done),
    .rd_data(rd_data), .scl(scl), .sda_out(sda_out), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [3:0] data;
    logic [7:0] reply;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: queue the expectation, then present the request
  task automatic access(input logic wr, input logic [3:0] a, input logic [3:0] d,
                        input logic [7:0] reply);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.reply = reply;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    chk(ready == 1'b0, "R2 ready low after accept", ready, 0);
    req_valid = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  // monitor and far-end model
  initial begin : mon
    logic p_scl, p_rdy, p_oe, p_sda, p_done, active, rxm;
    int lo, hi, nb, bc;
    logic [7:0] sh, expb;
    logic [3:0] exp_rd;
    item_t cur;
    p_scl = 1; p_rdy = 1; p_oe = 0; p_sda = 0; p_done = 0; active = 0; rxm = 0;
    lo = 0; hi = HALF; nb = 0; bc = 0; sh = 0; exp_rd = 0; cur = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        p_scl = scl; p_rdy = ready; p_oe = sda_oe; p_sda = sda_out; p_done = 0;
        hi = HALF; lo = 0;
      end else begin
        if (p_rdy && !ready) begin
          chk(q.size() > 0, "R2 one access per request", q.size(), 1);
          if (q.size() > 0) cur = q.pop_front();
          active = 1; rxm = 0; nb = 0; bc = 0;
        end
        if (ready) chk(scl == 1'b1, "R9 scl idle high", scl, 1);
        if (sda_oe && !p_oe)
          chk(scl && (p_sda == sda_out) && (sda_out == 1'b0), "R6 enable after placement",
              {scl, p_sda, sda_out}, 3'b100);
        if (p_scl && !scl) begin
          chk(hi >= HALF, "R3 high time", hi, HALF);
          hi = 0;
          if (active) begin
            if (!rxm) begin
              chk(sda_oe == 1'b1, "R6 enable during sent bit", sda_oe, 1);
              sh = {sh[6:0], sda_out};
            end else begin
              chk(sda_oe == 1'b0, "R5 line released while receiving", sda_oe, 0);
            end
            bc++;
          end
        end
        if (!p_scl && scl) begin
          chk(lo == HALF, "R3 low time", lo, HALF);
          lo = 0;
          if (active && bc == 8) begin
            if (!rxm) begin
              chk(sda_oe == 1'b0, "R6 release after eighth bit", sda_oe, 0);
              if (nb == 0) begin
                expb = cur.wr ? (8'h20 | 8'(cur.addr)) : (8'h60 | 8'(cur.addr));
                chk(sh == expb, cur.wr ? "R4 write command byte" : "R5 read command byte",
                    sh, expb);
              end else begin
                expb = 8'h10 | 8'(cur.data);
                chk(sh == expb, "R4 write data byte", sh, expb);
              end
            end
            nb++; bc = 0;
            if (nb == 1 && !cur.wr) begin
              rxm = 1;
              sda_in = cur.reply[7];
            end
          end else if (active && rxm && nb == 1 && bc < 8) begin
            sda_in = cur.reply[7-bc];
          end
        end
        if (scl) hi++; else lo++;
        if (p_done) chk(done == 1'b0, "R8 done single cycle", done, 0);
        if (done) begin
          chk(active == 1'b1, "R8 done ends an access", active, 1);
          chk(ready == 1'b1, "R8 ready with done", ready, 1);
          chk(nb == 2, cur.wr ? "R4 two bytes per write" : "R5 one byte out one in", nb, 2);
          if (!cur.wr) begin
            exp_rd = cur.reply[3:0];
            chk(rd_data == exp_rd, "R7 low nibble returned", rd_data, exp_rd);
          end else begin
            chk(rd_data == exp_rd, "R8 write keeps rd_data", rd_data, exp_rd);
          end
          active = 0; rxm = 0; sda_in = 1'b0;
        end
        p_scl = scl; p_rdy = ready; p_oe = sda_oe; p_sda = sda_out; p_done = done;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: access never completed, actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    ce = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl == 1'b1,     "R1 reset scl",     scl, 1);
    chk(sda_oe == 1'b0,  "R1 reset sda_oe",  sda_oe, 0);
    chk(ready == 1'b1,   "R1 reset ready",   ready, 1);
    chk(done == 1'b0,    "R1 reset done",    done, 0);
    chk(rd_data == 4'h0, "R1 reset rd_data", rd_data, 0);

    // R10: request with the enable low is not taken
    ce = 1'b0; req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h3; req_data = 4'h5;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(ready && scl && !sda_oe, "R10 ignored while ce low", {ready, scl, sda_oe}, 3'b110);
    end
    req_valid = 1'b0; ce = 1'b1;

    access(1'b1, 4'h0, 4'h9, 8'h00);
    access(1'b1, 4'hF, 4'hF, 8'h00);
    access(1'b0, 4'hE, 4'h0, 8'hA5);
    access(1'b1, 4'h7, 4'h0, 8'h00);
    access(1'b0, 4'h0, 4'h0, 8'h0F);
    access(1'b0, 4'h5, 4'h0, 8'hF0);
    access(1'b0, 4'hA, 4'h0, 8'h3C);
    access(1'b1, 4'h2, 4'h6, 8'h00);
    access(1'b0, 4'h9, 4'h0, 8'h96);

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2 every request served", q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule